// File: doc/BRIEF.md
# Memory Sleep-Mode Controller

This block sequences a synchronous memory into and out of a low-power sleep state. It takes an asynchronous, active-high sleep request, passes it through a two-stage synchroniser, and walks a four-phase sequence: awake, entering, asleep and recovering. On the way in, the memory is deselected and any pending access is flushed. While the memory is asleep, the data outputs are held at high impedance. On the way out, a fixed recovery window must pass before accesses are accepted again.

The chip-select and the two address strobes (processor and controller) enter the block active high. They reach the downstream cycle decoder only while the block is awake. In every other phase they are blocked, so a memory that is asleep or recovering never starts a cycle. A strobe or select seen during recovery breaks the usage rule, and the block reports it on a one-cycle error pulse. The sleep-active flag stands in for the analog power gating, which is outside this block. Stored contents are untouched because no access can reach the array.

Top module: `mem_sleep_ctrl`

## Requirements
- R1: While reset is low, and right after it is released, the block is awake: `force_desel_o`, `sleep_o`, `out_hiz_o`, `flush_o` and `recov_err_o` are 0, and the select and strobes pass through unchanged.
- R2: `sleep_req_i` passes through two synchroniser flops before it is acted on. A request driven before clock edge e0 leaves `force_desel_o` at 0 after edges e0 and e1, and raises it after edge e2.
- R3: Entry phase. `force_desel_o` rises one cycle after the synchronised request is seen high. `sleep_o` rises after exactly ENTRY_CYC (default 2) cycles of deselect. With the default, `sleep_o` is 1 after edge e4 and 0 before it.
- R4: `flush_o` is 1 for exactly the first cycle of the entry phase. It marks the pending access as invalid.
- R5: `sleep_o` is 1 only while asleep. `out_hiz_o` is 1 in every phase except awake, which covers the sleep period and the exit from it.
- R6: Exit phase. One cycle after the synchronised request is seen low while asleep, `sleep_o` falls and a recovery of EXIT_CYC (default 2) cycles starts. `force_desel_o` and `out_hiz_o` stay 1 until the recovery ends.
- R7: `sel_o`, `strb_proc_o` and `strb_ctrl_o` equal their inputs while awake and are 0 in every other phase.
- R8: `recov_err_o` is 1 for the one cycle after each recovery cycle in which `sel_i`, `strb_proc_i` or `strb_ctrl_i` was 1. Otherwise it is 0.
- R9: Once started, entry and recovery always run their full length. If the request is a single cycle long, the block still reaches sleep and then recovers fully: after edge e4 `sleep_o` is 1, and after edge e7 `force_desel_o` is 0. A request that returns during recovery does not shorten the recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_req_i | input | 1 | Asynchronous sleep request, active high; tie low when unused |
| sel_i | input | 1 | Combined chip select from the host, active high |
| strb_proc_i | input | 1 | Processor address strobe, active high |
| strb_ctrl_i | input | 1 | Controller address strobe, active high |
| sel_o | output | 1 | Select to the cycle decoder, blocked unless awake |
| strb_proc_o | output | 1 | Processor strobe to the cycle decoder, blocked unless awake |
| strb_ctrl_o | output | 1 | Controller strobe to the cycle decoder, blocked unless awake |
| force_desel_o | output | 1 | Forces the cycle decoder to deselect |
| flush_o | output | 1 | One-cycle pulse that discards the pending access |
| sleep_o | output | 1 | Sleep-active flag |
| out_hiz_o | output | 1 | Holds the data outputs at high impedance |
| recov_err_o | output | 1 | One-cycle flag for a strobe or select seen during recovery |

## Verification
Two events can fall in the same cycle: a strobe arriving on the last recovery cycle, and recovery finishing. The strobe must be blocked and flagged. A strobe on the following cycle must pass with no flag. The bench provokes this with random strobes on every cycle and with requests that toggle often and briefly, including single-cycle pulses and requests that come back during recovery. A bench reference model of the phases, written from the requirements, judges every output at every cycle. Literal checks at the edges counted in R2, R3 and R9 back up the model.

// File: rtl/mem_sleep_pkg.sv
package mem_sleep_pkg;
  typedef enum logic [1:0] {
    PH_AWAKE  = 2'd0,
    PH_ENTER  = 2'd1,
    PH_ASLEEP = 2'd2,
    PH_EXIT   = 2'd3
  } sleep_phase_e;
endpackage

// File: rtl/sleep_sync.sv
module sleep_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sleep_seq.sv
module sleep_seq
  import mem_sleep_pkg::*;
#(
  parameter int ENTRY_CYC = 2,
  parameter int EXIT_CYC  = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sleep_i,
  input  logic         access_i,
  output sleep_phase_e phase_o,
  output logic         flush_o,
  output logic         err_o
);
  localparam int CNT_MAX = (ENTRY_CYC > EXIT_CYC) ? ENTRY_CYC : EXIT_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  sleep_phase_e phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic err_q;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    unique case (phase_q)
      PH_AWAKE: if (sleep_i) begin
        phase_d = PH_ENTER;
        cnt_d   = '0;
      end
      PH_ENTER: begin
        if (cnt_q == CNT_W'(ENTRY_CYC - 1)) begin
          phase_d = PH_ASLEEP;
          cnt_d   = '0;
        end else cnt_d = cnt_q + CNT_W'(1);
      end
      PH_ASLEEP: if (!sleep_i) begin
        phase_d = PH_EXIT;
        cnt_d   = '0;
      end
      PH_EXIT: begin
        if (cnt_q == CNT_W'(EXIT_CYC - 1)) begin
          phase_d = PH_AWAKE;
          cnt_d   = '0;
        end else cnt_d = cnt_q + CNT_W'(1);
      end
      default: begin
        phase_d = PH_AWAKE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_AWAKE;
      cnt_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      err_q   <= (phase_q == PH_EXIT) && access_i;
    end
  end

  assign phase_o = phase_q;
  assign flush_o = (phase_q == PH_ENTER) && (cnt_q == '0);
  assign err_o   = err_q;

  AST_FLUSH_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> !flush_o); // R4
  AST_ERR_IN_RECOV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(phase_q == PH_EXIT)); // R8
  AST_SLEEP_FROM_ENTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_ASLEEP && $past(phase_q) != PH_ASLEEP) |-> $past(phase_q) == PH_ENTER); // R3
  AST_WAKE_FROM_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_AWAKE && $past(phase_q) != PH_AWAKE) |-> $past(phase_q) == PH_EXIT); // R6
endmodule

// File: rtl/access_gate.sv
module access_gate #(
  parameter int LINES = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             open_i,
  input  logic [LINES-1:0] req_i,
  output logic [LINES-1:0] req_o
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    assign req_o[g] = req_i[g] & open_i;
  end

  AST_GATE_CLOSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !open_i |-> (req_o == '0)); // R7
endmodule

// File: rtl/mem_sleep_ctrl.sv
module mem_sleep_ctrl
  import mem_sleep_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ENTRY_CYC   = 2,
  parameter int EXIT_CYC    = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sleep_req_i,
  input  logic sel_i,
  input  logic strb_proc_i,
  input  logic strb_ctrl_i,
  output logic sel_o,
  output logic strb_proc_o,
  output logic strb_ctrl_o,
  output logic force_desel_o,
  output logic flush_o,
  output logic sleep_o,
  output logic out_hiz_o,
  output logic recov_err_o
);
  localparam int LINES = 3;

  logic sleep_sync_w;
  sleep_phase_e phase_w;
  logic [LINES-1:0] acc_in, acc_out;

  assign acc_in = {strb_ctrl_i, strb_proc_i, sel_i};

  sleep_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sleep_req_i),
    .q_o   (sleep_sync_w)
  );

  sleep_seq #(.ENTRY_CYC(ENTRY_CYC), .EXIT_CYC(EXIT_CYC)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sleep_i (sleep_sync_w),
    .access_i(|acc_in),
    .phase_o (phase_w),
    .flush_o (flush_o),
    .err_o   (recov_err_o)
  );

  access_gate #(.LINES(LINES)) u_gate (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .open_i(phase_w == PH_AWAKE),
    .req_i (acc_in),
    .req_o (acc_out)
  );

  assign sel_o         = acc_out[0];
  assign strb_proc_o   = acc_out[1];
  assign strb_ctrl_o   = acc_out[2];
  assign force_desel_o = (phase_w != PH_AWAKE);
  assign out_hiz_o     = (phase_w != PH_AWAKE);
  assign sleep_o       = (phase_w == PH_ASLEEP);

  AST_SLEEP_DESEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_o |-> (force_desel_o && out_hiz_o)); // R5
  AST_DESEL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_desel_o |-> !(sel_o || strb_proc_o || strb_ctrl_o)); // R7
  AST_ENTRY_NOT_ASLEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(force_desel_o) |-> !sleep_o); // R3
endmodule

// File: tb/mem_sleep_ctrl_bench.sv
module mem_sleep_ctrl_bench;
  localparam int ENTRY_CYC = 2;
  localparam int EXIT_CYC  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, sel = 1'b0, sp = 1'b0, sc = 1'b0;
  logic sel_o, sp_o, sc_o, desel_o, flush_o, sleep_o, hiz_o, err_o;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  always #10 clk = ~clk;

  mem_sleep_ctrl #(.SYNC_STAGES(2), .ENTRY_CYC(ENTRY_CYC), .EXIT_CYC(EXIT_CYC)) u_mem_sleep_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .sleep_req_i(req), .sel_i(sel),
    .strb_proc_i(sp), .strb_ctrl_i(sc), .sel_o(sel_o), .strb_proc_o(sp_o),
    .strb_ctrl_o(sc_o), .force_desel_o(desel_o), .flush_o(flush_o),
    .sleep_o(sleep_o), .out_hiz_o(hiz_o), .recov_err_o(err_o)
  );

  // reference model: 0 awake, 1 entering, 2 asleep, 3 recovering
  logic m_s1, m_s2, m_err;
  int   m_ph, m_cnt;

  function automatic int next_ph(int ph, int cnt, logic s);
    case (ph)
      0: return s ? 1 : 0;
      1: return (cnt == ENTRY_CYC - 1) ? 2 : 1;
      2: return s ? 2 : 3;
      default: return (cnt == EXIT_CYC - 1) ? 0 : 3;
    endcase
  endfunction

  function automatic int next_cnt(int ph, int cnt, logic s);
    if (next_ph(ph, cnt, s) != ph) return 0;
    if (ph == 1 || ph == 3) return cnt + 1;
    return cnt;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 1'b0; m_s2 <= 1'b0; m_err <= 1'b0; m_ph <= 0; m_cnt <= 0;
    end else begin
      m_s1  <= req;
      m_s2  <= m_s1;
      m_err <= (m_ph == 3) && (sel || sp || sc);
      m_ph  <= next_ph(m_ph, m_cnt, m_s2);
      m_cnt <= next_cnt(m_ph, m_cnt, m_s2);
    end
  end

  task automatic check(string tag, string what, logic act, logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%0b exp=%0b cycle=%0d", tag, what, act, exp, cyc);
    end
  endtask

  task automatic check_model();
    logic awake;
    awake = (m_ph == 0);
    check("R7", "sel_o", sel_o, sel & awake);
    check("R7", "strb_proc_o", sp_o, sp & awake);
    check("R7", "strb_ctrl_o", sc_o, sc & awake);
    check((m_ph == 3) ? "R6" : "R3", "force_desel_o", desel_o, !awake);
    check("R5", "sleep_o", sleep_o, m_ph == 2);
    check("R5", "out_hiz_o", hiz_o, !awake);
    check("R4", "flush_o", flush_o, (m_ph == 1) && (m_cnt == 0));
    check("R8", "recov_err_o", err_o, m_err);
  endtask

  // drive at negedge, sample 2 ns later
  task automatic step(logic r, logic s, logic p, logic c);
    @(negedge clk);
    req = r; sel = s; sp = p; sc = c;
    #2;
    check_model();
  endtask

  task automatic step_rand(logic r);
    step(r, 1'($urandom), 1'($urandom), 1'($urandom));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    // R1: reset state
    @(negedge clk);
    sel = 1'b1; sp = 1'b1; sc = 1'b1;
    #2;
    check("R1", "desel in reset", desel_o, 1'b0);
    check("R1", "sleep in reset", sleep_o, 1'b0);
    check("R1", "hiz in reset", hiz_o, 1'b0);
    check("R1", "flush in reset", flush_o, 1'b0);
    check("R1", "err in reset", err_o, 1'b0);
    check("R1", "sel passes in reset", sel_o, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 10; i++) step_rand(1'b0);
    check("R1", "desel after reset", desel_o, 1'b0);

    // R2/R3 literal timing: step k samples after edge e(k-1)
    step(1'b1, 1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0, 1'b0); check("R2", "desel after e0", desel_o, 1'b0);
    step(1'b1, 1'b0, 1'b0, 1'b0); check("R2", "desel after e1", desel_o, 1'b0);
    step(1'b1, 1'b0, 1'b0, 1'b0); check("R2", "desel after e2", desel_o, 1'b1);
    check("R4", "flush after e2", flush_o, 1'b1);
    step(1'b1, 1'b1, 1'b1, 1'b1); check("R3", "sleep after e3", sleep_o, 1'b0);
    check("R4", "flush after e3", flush_o, 1'b0);
    check("R7", "sel blocked entering", sel_o, 1'b0);
    step(1'b1, 1'b0, 1'b0, 1'b0); check("R3", "sleep after e4", sleep_o, 1'b1);
    for (int i = 0; i < 8; i++) step_rand(1'b1);
    for (int i = 0; i < 12; i++) step_rand(1'b0);
    check("R6", "awake after exit", desel_o, 1'b0);

    // R9: single-cycle request
    step(1'b1, 1'b0, 1'b0, 1'b0);
    for (int k = 1; k <= 8; k++) begin
      step(1'b0, 1'b0, 1'b0, 1'b0);
      if (k == 5) check("R9", "sleep after e4", sleep_o, 1'b1);
      if (k == 6) check("R9", "recovering after e5", desel_o, 1'b1);
      if (k == 8) check("R9", "awake after e7", desel_o, 1'b0);
    end

    // R8/R9: strobes on every recovery cycle, request back during recovery
    for (int i = 0; i < 10; i++) step(1'b1, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 12; i++) step(1'b0, 1'b1, 1'b0, 1'b1);

    // random phase: request toggles with probability 1/8
    begin
      logic r;
      r = 1'b0;
      for (int i = 0; i < 4000; i++) begin
        if (($urandom % 8) == 0) r = ~r;
        step_rand(r);
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule